// File: doc/BRIEF.md
# Bidirectional Universal Shift Register

This block is a parameterised register (eight bits by default) that on every rising clock edge either keeps its contents, moves them one place toward the high end, moves them one place toward the low end, or captures a word from a shared parallel bus. A two-bit select picks the operation. The parallel pins are shared between the load input and the register output, so the block has a drive-enable that turns the pin drivers off during a load and whenever either of two active-low output enables is deasserted (high).

For cascading several registers into a longer chain, there is one serial input for each shift direction. The lowest and highest stages are also brought out on two serial taps that are always valid. An active-low asynchronous reset clears the register at once, whatever the select and clock are doing.

The tri-state pins are split into an input word, an output word and a single drive-enable, so that a pad ring or a resolved wire can be attached outside.

The operating modes are handled as four named states. The select value chosen before each clock edge decides the next state:
- `MODE_KEEP` (select 00) holds the contents.
- `MODE_RIGHT` (select 01) shifts toward the high end.
- `MODE_LEFT` (select 10) shifts toward the low end.
- `MODE_LOAD` (select 11) loads from the bus.

Top module: `ushift_bidir`

## Requirements
- R1: While `rst_n` is low, the register reads all zeros. The clear takes effect without waiting for a clock edge and overrides both the select and the clock.
- R2: With `sel` = 00, a rising edge leaves the register unchanged.
- R3: With `sel` = 01, a rising edge moves `ser_r_in` into bit 0 and each bit i into bit i+1. The old top bit is dropped.
- R4: With `sel` = 10, a rising edge moves `ser_l_in` into the top bit and each bit i into bit i-1. The old bit 0 is dropped.
- R5: With `sel` = 11, a rising edge copies `bus_in` into the register.
- R6: `bus_drive` is low whenever `oe_a_n` or `oe_b_n` is high.
- R7: `bus_drive` is low whenever `sel` = 11, whatever the enables are.
- R8: While `bus_drive` is low because of the output enables, the hold, shift, load and reset operations still change the register exactly as in R1 to R5.
- R9: `tap_lo` always equals register bit 0 and `tap_hi` always equals the top register bit, independent of the output enables.
- R10: `bus_out` always carries the register contents. When both enables are low and `sel` is not 11, `bus_drive` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| sel | input | 2 | Mode select: 00 keep, 01 shift toward the high end, 10 shift toward the low end, 11 load |
| ser_r_in | input | 1 | Serial input that enters bit 0 on a right shift |
| ser_l_in | input | 1 | Serial input that enters the top bit on a left shift |
| oe_a_n | input | 1 | Active-low output enable A |
| oe_b_n | input | 1 | Active-low output enable B |
| bus_in | input | W | Value seen on the shared pins |
| bus_out | output | W | Register contents offered to the pins |
| bus_drive | output | 1 | High when the block drives the pins |
| tap_lo | output | 1 | Bit 0 of the register |
| tap_hi | output | 1 | Top bit of the register |

## Verification
A fixed table walks through each mode with distinct data words and alternating serial bits. Because the patterns differ, a swapped shift direction or a wrong entry bit shows up on the first shift. The table also mixes in all four enable combinations, which separates the two enable paths from the load-mode turn-off.

A long random run of modes, compared against a reference model, tells apart mistakes that only appear after mixed sequences, such as loads captured from the wrong source. Directed steps then shift and load with the drivers off, to prove that the register keeps working through the taps. They also pull reset in the middle of a clock period during a load, to prove that the clear is immediate and beats the clock.

// File: rtl/usr_pkg.sv
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_KEEP  = 2'b00,
        MODE_RIGHT = 2'b01,
        MODE_LEFT  = 2'b10,
        MODE_LOAD  = 2'b11
    } usr_mode_e;

endpackage

// File: rtl/usr_mode_decode.sv
module usr_mode_decode
    import usr_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       oe_a_n,
    input  logic       oe_b_n,
    output usr_mode_e  mode,
    output logic       drive_en
);

    always_comb begin
        unique case (sel)
            2'b00:   mode = MODE_KEEP;
            2'b01:   mode = MODE_RIGHT;
            2'b10:   mode = MODE_LEFT;
            default: mode = MODE_LOAD;
        endcase
    end

    // Pins are released when either enable is high or a load is about to sample them.
    always_comb begin
        drive_en = 1'b1;
        if (oe_a_n || oe_b_n)    drive_en = 1'b0;
        if (mode == MODE_LOAD)   drive_en = 1'b0;
    end

endmodule

// File: rtl/usr_shift_core.sv
module usr_shift_core
    import usr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  usr_mode_e    mode,
    input  logic         ser_r_in,
    input  logic         ser_l_in,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] q
);

    localparam int TOP = W - 1;

    logic [W-1:0] from_lo;   // source for a shift toward the high end
    logic [W-1:0] from_hi;   // source for a shift toward the low end
    logic [W-1:0] nxt;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_cell
            if (i == 0) begin : g_lo_end
                assign from_lo[i] = ser_r_in;
            end else begin : g_lo_mid
                assign from_lo[i] = q[i-1];
            end

            if (i == TOP) begin : g_hi_end
                assign from_hi[i] = ser_l_in;
            end else begin : g_hi_mid
                assign from_hi[i] = q[i+1];
            end

            always_comb begin
                unique case (mode)
                    MODE_KEEP:  nxt[i] = q[i];
                    MODE_RIGHT: nxt[i] = from_lo[i];
                    MODE_LEFT:  nxt[i] = from_hi[i];
                    MODE_LOAD:  nxt[i] = par_in[i];
                    default:    nxt[i] = q[i];
                endcase
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |-> (q == '0));

    // R2
    keep_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_KEEP) |=> (q == $past(q)));

    // R3
    right_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RIGHT) |=> (q == {$past(q[W-2:0]), $past(ser_r_in)}));

    // R4
    left_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LEFT) |=> (q == {$past(ser_l_in), $past(q[W-1:1])}));

    // R5
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOAD) |=> (q == $past(par_in)));

endmodule

// File: rtl/ushift_bidir.sv
module ushift_bidir
    import usr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   sel,
    input  logic         ser_r_in,
    input  logic         ser_l_in,
    input  logic         oe_a_n,
    input  logic         oe_b_n,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] bus_out,
    output logic         bus_drive,
    output logic         tap_lo,
    output logic         tap_hi
);

    usr_mode_e    mode;
    logic         drive_en;
    logic [W-1:0] q;

    usr_mode_decode u_dec (
        .sel      (sel),
        .oe_a_n   (oe_a_n),
        .oe_b_n   (oe_b_n),
        .mode     (mode),
        .drive_en (drive_en)
    );

    usr_shift_core #(.W(W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .ser_r_in (ser_r_in),
        .ser_l_in (ser_l_in),
        .par_in   (bus_in),
        .q        (q)
    );

    assign bus_out   = q;
    assign bus_drive = drive_en;
    assign tap_lo    = q[0];
    assign tap_hi    = q[W-1];

    // R6
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_a_n || oe_b_n) |-> !bus_drive);

    // R7
    load_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b11) |-> !bus_drive);

    // R10
    drive_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_a_n && !oe_b_n && sel != 2'b11) |-> bus_drive);

endmodule

// File: tb/ushift_bidir_tb.sv
`timescale 1ns/1ps
module ushift_bidir_tb;

    localparam int W = 8;
    localparam int NVEC = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic [1:0]   sel = 2'b00;
    logic         ser_r_in = 1'b0;
    logic         ser_l_in = 1'b0;
    logic         oe_a_n = 1'b0;
    logic         oe_b_n = 1'b0;
    logic [W-1:0] ext_val = '0;
    logic [W-1:0] bus_out;
    logic         bus_drive;
    logic         tap_lo;
    logic         tap_hi;
    wire  [W-1:0] pad;

    logic [W-1:0] mdl = '0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    assign pad = bus_drive ? bus_out : 'z;
    assign pad = bus_drive ? 'z : ext_val;

    always #2.5 clk = ~clk;

    ushift_bidir #(.W(W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .ser_r_in  (ser_r_in),
        .ser_l_in  (ser_l_in),
        .oe_a_n    (oe_a_n),
        .oe_b_n    (oe_b_n),
        .bus_in    (pad),
        .bus_out   (bus_out),
        .bus_drive (bus_drive),
        .tap_lo    (tap_lo),
        .tap_hi    (tap_hi)
    );

    // {sel, ser_r, ser_l, oe_a_n, oe_b_n, data}
    localparam logic [13:0] VEC [NVEC] = '{
        {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
        {2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00},
        {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF},
        {2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
        {2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 8'h3C},
        {2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
        {2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF},
        {2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00},
        {2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 8'h81},
        {2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h7E},
        {2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01},
        {2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 8'hAA},
        {2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h55},
        {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'h80},
        {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
        {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC3}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Entered just after a falling edge; returns just after the next falling edge.
    task automatic step(input logic [1:0] s, input logic sr, input logic sl,
                        input logic oa, input logic ob, input logic [W-1:0] d);
        string tag;
        sel = s; ser_r_in = sr; ser_l_in = sl; oe_a_n = oa; oe_b_n = ob; ext_val = d;
        #1;
        if (oa || ob)        chk("R6", bus_drive, 1'b0);
        else if (s == 2'b11) chk("R7", bus_drive, 1'b0);
        else                 chk("R10", bus_drive, 1'b1);
        @(posedge clk);
        case (s)
            2'b00: mdl = mdl;
            2'b01: mdl = {mdl[W-2:0], sr};
            2'b10: mdl = {sl, mdl[W-1:1]};
            default: mdl = d;
        endcase
        @(negedge clk);
        case (s)
            2'b00: tag = "R2";
            2'b01: tag = "R3";
            2'b10: tag = "R4";
            default: tag = "R5";
        endcase
        if (oa || ob) tag = {tag, " R8"};
        chk(tag, bus_out, mdl);
        chk("R9", {tap_hi, tap_lo}, {mdl[W-1], mdl[0]});
        if (bus_drive) chk("R10", pad, mdl);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1 rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", bus_out, '0);
        chk("R9", {tap_hi, tap_lo}, 2'b00);
        rst_n = 1'b1;
        mdl = '0;

        for (int k = 0; k < NVEC; k++) begin
            step(VEC[k][13:12], VEC[k][11], VEC[k][10], VEC[k][9], VEC[k][8], VEC[k][7:0]);
        end

        for (int k = 0; k < 300; k++) begin
            step(2'($urandom), 1'($urandom), 1'($urandom),
                 1'(($urandom % 4) == 0), 1'(($urandom % 4) == 0), 8'($urandom));
        end

        // R8: drivers off, register keeps working; state seen through taps and bus_out.
        step(2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 8'h96);
        step(2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
        step(2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
        step(2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF);
        step(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);

        // R1: mid-period reset during a load overrides select and clock.
        step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF);
        sel = 2'b11; ext_val = 8'h5A; oe_a_n = 1'b1;
        #1 rst_n = 1'b0;
        #0.5;
        chk("R1", bus_out, '0);
        @(posedge clk);
        @(negedge clk);
        chk("R1", bus_out, '0);
        chk("R9", {tap_hi, tap_lo}, 2'b00);
        rst_n = 1'b1;
        mdl = '0;
        step(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        step(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
        step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule